// File: doc/BRIEF.md
# Mode Register Latency and DLL Gate

This block keeps a copy of the first DDR3-style mode register of a memory device and turns its fields into the timing numbers and permissions that a memory controller needs. A controller writes the 13-bit register image through a single strobe. From the stored image the block derives the read latency, the write recovery count and the auto-precharge delay. It also gates commands after a DLL reset and after leaving precharge power-down.

A DLL reset request never stays in the stored image. It produces a one-cycle pulse and starts a lock window. Reads and synchronous termination requests are refused during that window. Power-down entry and exit events come in as single-cycle pulses. The wait after exit is short when the stored power-down mode keeps the DLL running, and long when the DLL was frozen. Reserved latency codes are refused, and the affected field keeps its previous value. The vendor test-mode bit raises a fault and blocks every command. Requests made while the matching qualifier is low are reported one cycle later.

Top module: `mr0_timing_gate`

## Requirements
- R1: Bits 6:4 hold the CAS code c. Code c from 1 to 7 gives CL = CL_MIN + c - 1 cycles. `read_lat` equals `add_lat` + CL in whole cycles and follows `add_lat` combinationally.
- R2: When bit 7 of the stored image is 1, `test_fault` is 1 and both `cmd_ok` and `rd_ok` are 0.
- R3: Writing bit 8 as 1 raises `dll_rst_pulse` for exactly one cycle, starting one clock after the write. Bit 8 of `mr_image` always reads 0.
- R4: After a write with bit 8 set, `rd_ok` is 0 for TDLLK cycles after the write edge and returns to 1 in the TDLLK-th cycle.
- R5: Bits 11:9 hold the write-recovery code w. Codes 1 to 4 give 4+w cycles, and codes 5 to 7 give 2*w cycles. `wr_short_err` is 1 while that count is below WR_MIN.
- R6: `ap_delay` equals `wr_rec` + TRP.
- R7: With bit 12 = 0 (slow exit), `cmd_ok` and `rd_ok` are 0 and `dll_frozen` is 1 while in power-down. After the exit pulse, `cmd_ok` stays 0 for TXPDLL cycles.
- R8: With bit 12 = 1 (fast exit), `dll_frozen` stays 0 during power-down. After the exit pulse, `cmd_ok` stays 0 for TXP cycles. An exit pulse outside power-down has no effect.
- R9: A write with CAS code 0 or write-recovery code 0 sets `illegal_err`. The reserved field keeps its previous value, in `mr_image` and in the derived count. Other fields still update. The next fully legal write clears `illegal_err`.
- R10: A register write takes effect at the next clock edge. A repeated DLL reset restarts the lock window from the new write.
- R11: `req_err` is 1 in the cycle after `cmd_req` was high with `cmd_ok` low, or `rd_req` was high with `rd_ok` low. Otherwise it is 0.
- R12: After reset, `mr_image` is 0x410 (CAS code 1, write-recovery code 2), no flag is raised, and `cmd_ok` and `rd_ok` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mrs_wr | input | 1 | Mode register write strobe |
| mrs_word | input | 13 | Register image to write |
| add_lat | input | AL_W | Additive latency in cycles |
| pd_enter | input | 1 | Precharge power-down entry event |
| pd_exit | input | 1 | Precharge power-down exit event |
| cmd_req | input | 1 | Any command request |
| rd_req | input | 1 | Read or synchronous termination request |
| mr_image | output | 13 | Stored register image |
| read_lat | output | LAT_W | Read latency in cycles |
| wr_rec | output | WR_W | Write recovery in cycles |
| ap_delay | output | DAL_W | Auto-precharge delay in cycles |
| dll_rst_pulse | output | 1 | One-cycle DLL reset pulse |
| dll_frozen | output | 1 | DLL frozen during slow-exit power-down |
| cmd_ok | output | 1 | Commands allowed |
| rd_ok | output | 1 | Reads and synchronous termination allowed |
| test_fault | output | 1 | Test mode selected; operation invalid |
| wr_short_err | output | 1 | Write recovery below the minimum |
| illegal_err | output | 1 | Last write carried a reserved code |
| req_err | output | 1 | Request made while not allowed |

## Verification
The bench probes the last cycle of each wait window: the TDLLK-th cycle after a DLL reset, and the TXP-th and TXPDLL-th cycles after exit. An off-by-one counter would open a read or command slot one cycle early or late. It issues a second DLL reset midway through the window. A design that does not restart would let reads through early. It writes reserved codes next to legal ones in the same word. A design that drops the whole write, or accepts the reserved field, would show the wrong readback or latency. It sweeps all CAS and write-recovery codes against the minimum and checks that an exit pulse outside power-down is ignored.

// File: rtl/mr0_timing_pkg.sv
package mr0_timing_pkg;

  localparam int MR_W       = 13;
  localparam int CL_LSB     = 4;
  localparam int TEST_BIT   = 7;
  localparam int DLLRST_BIT = 8;
  localparam int WR_LSB     = 9;
  localparam int PDX_BIT    = 12;

  // CAS code 1, write-recovery code 2, everything else zero
  localparam logic [MR_W-1:0] MR_RESET = 13'h0410;

  function automatic logic cl_code_ok(input logic [2:0] code);
    return code != 3'd0;
  endfunction

  function automatic int cl_cycles(input logic [2:0] code, input int cl_min);
    return cl_min + int'(code) - 1;
  endfunction

  function automatic logic wr_code_ok(input logic [2:0] code);
    return code != 3'd0;
  endfunction

  function automatic int wr_cycles(input logic [2:0] code);
    if (code <= 3'd4) return 4 + int'(code);
    else              return 2 * int'(code);
  endfunction

  function automatic int read_latency(input int al, input int cl);
    return al + cl;
  endfunction

  function automatic int ap_latency(input int wr, input int trp);
    return wr + trp;
  endfunction

endpackage

// File: rtl/mr0_field_reg.sv
module mr0_field_reg
  import mr0_timing_pkg::*;
#(
  parameter int CL_MIN = 5,
  parameter int CL_W   = 4,
  parameter int WR_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [MR_W-1:0] wr_word,
  output logic [MR_W-1:0] mr_q,
  output logic [CL_W-1:0] cl_cyc,
  output logic [WR_W-1:0] wr_cyc,
  output logic            dll_pulse,
  output logic            illegal
);

  logic [2:0]      new_cl, new_wr;
  logic            cl_ok, wr_ok;
  logic [MR_W-1:0] next_word;

  always_comb begin
    new_cl    = wr_word[CL_LSB +: 3];
    new_wr    = wr_word[WR_LSB +: 3];
    cl_ok     = cl_code_ok(new_cl);
    wr_ok     = wr_code_ok(new_wr);
    next_word = wr_word;
    next_word[DLLRST_BIT] = 1'b0;
    if (!cl_ok) next_word[CL_LSB +: 3] = mr_q[CL_LSB +: 3];
    if (!wr_ok) next_word[WR_LSB +: 3] = mr_q[WR_LSB +: 3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q      <= MR_RESET;
      dll_pulse <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      dll_pulse <= wr_en && wr_word[DLLRST_BIT];
      if (wr_en) begin
        mr_q    <= next_word;
        illegal <= !(cl_ok && wr_ok);
      end
    end
  end

  assign cl_cyc = CL_W'(cl_cycles(mr_q[CL_LSB +: 3], CL_MIN));
  assign wr_cyc = WR_W'(wr_cycles(mr_q[WR_LSB +: 3]));

  AST_DLL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[DLLRST_BIT]) |=> (dll_pulse && !mr_q[DLLRST_BIT])); // R3
  AST_CL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !cl_ok) |=> ($stable(cl_cyc) && illegal)); // R9
  AST_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> ($stable(wr_cyc) && illegal)); // R9
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cl_ok) |=> (mr_q[CL_LSB +: 3] == $past(wr_word[CL_LSB +: 3]))); // R10

endmodule

// File: rtl/mr0_wait_timer.sv
module mr0_wait_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (clear)        cnt <= '0;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = cnt != '0;

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R10
  AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear && busy) |=> (cnt == $past(cnt) - 1'b1)); // R4

endmodule

// File: rtl/mr0_cmd_gate.sv
module mr0_cmd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_enter,
  input  logic pd_exit,
  input  logic pd_fast,
  input  logic test_mode,
  input  logic exit_busy,
  input  logic lock_busy,
  input  logic cmd_req,
  input  logic rd_req,
  output logic enter_evt,
  output logic exit_evt,
  output logic dll_frozen,
  output logic cmd_ok,
  output logic rd_ok,
  output logic req_err
);

  logic in_pd;

  assign enter_evt = pd_enter && !in_pd;
  assign exit_evt  = pd_exit && in_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pd   <= 1'b0;
      req_err <= 1'b0;
    end else begin
      if (enter_evt)     in_pd <= 1'b1;
      else if (exit_evt) in_pd <= 1'b0;
      req_err <= (cmd_req && !cmd_ok) || (rd_req && !rd_ok);
    end
  end

  assign cmd_ok     = !in_pd && !exit_busy && !test_mode;
  assign rd_ok      = cmd_ok && !lock_busy;
  assign dll_frozen = in_pd && !pd_fast;

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> (!dll_frozen && !rd_ok)); // R7
  AST_ENTER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> (!cmd_ok && !rd_ok)); // R7
  AST_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ok) |=> req_err); // R11

endmodule

// File: rtl/mr0_timing_gate.sv
module mr0_timing_gate
  import mr0_timing_pkg::*;
#(
  parameter int TDLLK  = 512,
  parameter int TXP    = 3,
  parameter int TXPDLL = 10,
  parameter int TRP    = 6,
  parameter int WR_MIN = 6,
  parameter int CL_MIN = 5,
  parameter int AL_W   = 4,
  localparam int CL_W    = $clog2(CL_MIN + 7),
  localparam int WR_W    = $clog2(15),
  localparam int LAT_W   = ((AL_W > CL_W) ? AL_W : CL_W) + 1,
  localparam int DAL_W   = $clog2(14 + TRP + 1),
  localparam int CNT_MAX = (TDLLK > TXPDLL) ? ((TDLLK > TXP) ? TDLLK : TXP)
                                            : ((TXPDLL > TXP) ? TXPDLL : TXP),
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_wr,
  input  logic [12:0]      mrs_word,
  input  logic [AL_W-1:0]  add_lat,
  input  logic             pd_enter,
  input  logic             pd_exit,
  input  logic             cmd_req,
  input  logic             rd_req,
  output logic [12:0]      mr_image,
  output logic [LAT_W-1:0] read_lat,
  output logic [WR_W-1:0]  wr_rec,
  output logic [DAL_W-1:0] ap_delay,
  output logic             dll_rst_pulse,
  output logic             dll_frozen,
  output logic             cmd_ok,
  output logic             rd_ok,
  output logic             test_fault,
  output logic             wr_short_err,
  output logic             illegal_err,
  output logic             req_err
);

  logic [CL_W-1:0]  cl_cyc;
  logic             dll_req, lock_busy, exit_busy;
  logic             enter_evt, exit_evt, pd_fast;
  logic [CNT_W-1:0] exit_wait;

  mr0_field_reg #(.CL_MIN(CL_MIN), .CL_W(CL_W), .WR_W(WR_W)) u_field (
    .clk(clk), .rst_n(rst_n), .wr_en(mrs_wr), .wr_word(mrs_word),
    .mr_q(mr_image), .cl_cyc(cl_cyc), .wr_cyc(wr_rec),
    .dll_pulse(dll_rst_pulse), .illegal(illegal_err)
  );

  assign dll_req = mrs_wr && mrs_word[DLLRST_BIT];

  mr0_wait_timer #(.CNT_W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(dll_req),
    .load_val(CNT_W'(TDLLK)), .clear(1'b0), .busy(lock_busy)
  );

  assign pd_fast   = mr_image[PDX_BIT];
  assign exit_wait = pd_fast ? CNT_W'(TXP) : CNT_W'(TXPDLL);

  mr0_wait_timer #(.CNT_W(CNT_W)) u_exit (
    .clk(clk), .rst_n(rst_n), .load(exit_evt),
    .load_val(exit_wait), .clear(enter_evt), .busy(exit_busy)
  );

  assign test_fault = mr_image[TEST_BIT];

  mr0_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pd_enter(pd_enter), .pd_exit(pd_exit),
    .pd_fast(pd_fast), .test_mode(test_fault), .exit_busy(exit_busy),
    .lock_busy(lock_busy), .cmd_req(cmd_req), .rd_req(rd_req),
    .enter_evt(enter_evt), .exit_evt(exit_evt), .dll_frozen(dll_frozen),
    .cmd_ok(cmd_ok), .rd_ok(rd_ok), .req_err(req_err)
  );

  assign read_lat     = LAT_W'(read_latency(int'(add_lat), int'(cl_cyc)));
  assign ap_delay     = DAL_W'(ap_latency(int'(wr_rec), TRP));
  assign wr_short_err = int'(wr_rec) < WR_MIN;

  AST_DLL_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst_pulse |-> !rd_ok); // R4
  AST_TEST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    test_fault |-> (!cmd_ok && !rd_ok)); // R2
  AST_EXIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    exit_evt |=> !cmd_ok); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dll_rst_pulse && !$past(dll_req)) |-> 1'b0); // R3

endmodule

// File: tb/mr0_timing_gate_tb_top.sv
module mr0_timing_gate_tb_top;

  localparam int TDLLK  = 512;
  localparam int TXP    = 3;
  localparam int TXPDLL = 10;
  localparam int TRP    = 6;
  localparam int WR_MIN = 6;
  localparam int CL_MIN = 5;
  localparam int AL_W   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_wr = 1'b0;
  logic [12:0] mrs_word = '0;
  logic [AL_W-1:0] add_lat = '0;
  logic        pd_enter = 1'b0, pd_exit = 1'b0, cmd_req = 1'b0, rd_req = 1'b0;
  logic [12:0] mr_image;
  logic [5:0]  read_lat;
  logic [3:0]  wr_rec;
  logic [4:0]  ap_delay;
  logic        dll_rst_pulse, dll_frozen, cmd_ok, rd_ok;
  logic        test_fault, wr_short_err, illegal_err, req_err;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mr0_timing_gate #(
    .TDLLK(TDLLK), .TXP(TXP), .TXPDLL(TXPDLL), .TRP(TRP),
    .WR_MIN(WR_MIN), .CL_MIN(CL_MIN), .AL_W(AL_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mrs_wr(mrs_wr), .mrs_word(mrs_word),
    .add_lat(add_lat), .pd_enter(pd_enter), .pd_exit(pd_exit),
    .cmd_req(cmd_req), .rd_req(rd_req), .mr_image(mr_image),
    .read_lat(read_lat), .wr_rec(wr_rec), .ap_delay(ap_delay),
    .dll_rst_pulse(dll_rst_pulse), .dll_frozen(dll_frozen),
    .cmd_ok(cmd_ok), .rd_ok(rd_ok), .test_fault(test_fault),
    .wr_short_err(wr_short_err), .illegal_err(illegal_err), .req_err(req_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [12:0] mk(input bit fast, input int wrc, input bit dll,
                                     input bit tst, input int clc, input int low);
    return {fast, 3'(wrc), dll, tst, 3'(clc), 4'(low)};
  endfunction

  function automatic int cl_of(input int c);
    return c + CL_MIN - 1;
  endfunction

  function automatic int wr_of(input int c);
    return (c > 4) ? c * 2 : c + 4;
  endfunction

  task automatic mrs(input logic [12:0] w);
    mrs_wr = 1'b1;
    mrs_word = w;
    cyc(1);
    mrs_wr = 1'b0;
    mrs_word = '0;
  endtask

  task automatic t_reset();
    check("R12", "image", int'(mr_image), 'h410);
    check("R12", "read_lat", int'(read_lat), CL_MIN);
    check("R12", "wr_rec", int'(wr_rec), 6);
    check("R6",  "ap_delay", int'(ap_delay), 6 + TRP);
    check("R12", "cmd_ok", int'(cmd_ok), 1);
    check("R12", "rd_ok", int'(rd_ok), 1);
    check("R12", "flags", int'({test_fault, wr_short_err, illegal_err, req_err, dll_frozen, dll_rst_pulse}), 0);
  endtask

  task automatic t_cas();
    mrs_wr = 1'b1;
    mrs_word = mk(0, 2, 0, 0, 4, 0);
    #1;
    check("R10", "latency before edge", int'(read_lat), CL_MIN);
    cyc(1);
    mrs_wr = 1'b0;
    check("R10", "latency after edge", int'(read_lat), cl_of(4));
    for (int c = 1; c < 8; c++) begin
      mrs(mk(0, 2, 0, 0, c, 0));
      for (int al = 0; al < 4; al += 3) begin
        add_lat = AL_W'(al);
        #1;
        check("R1", $sformatf("read_lat code %0d al %0d", c, al), int'(read_lat), cl_of(c) + al);
      end
    end
    add_lat = '0;
  endtask

  task automatic t_reserved();
    mrs(mk(0, 3, 0, 0, 3, 0));
    check("R9", "legal write clean", int'(illegal_err), 0);
    mrs(mk(0, 5, 0, 0, 0, 5));
    check("R9", "illegal cl flag", int'(illegal_err), 1);
    check("R9", "cl kept", int'(read_lat), cl_of(3));
    check("R9", "cl field kept", int'(mr_image[6:4]), 3);
    check("R9", "wr updated", int'(wr_rec), wr_of(5));
    check("R9", "low bits updated", int'(mr_image[3:0]), 5);
    mrs(mk(0, 0, 0, 0, 6, 0));
    check("R9", "illegal wr flag", int'(illegal_err), 1);
    check("R9", "wr kept", int'(wr_rec), wr_of(5));
    check("R9", "wr field kept", int'(mr_image[11:9]), 5);
    check("R9", "cl updated", int'(read_lat), cl_of(6));
    mrs(mk(0, 2, 0, 0, 1, 0));
    check("R9", "flag cleared", int'(illegal_err), 0);
  endtask

  task automatic t_wr();
    for (int w = 1; w < 8; w++) begin
      mrs(mk(0, w, 0, 0, 1, 0));
      check("R5", $sformatf("wr_rec code %0d", w), int'(wr_rec), wr_of(w));
      check("R5", $sformatf("short code %0d", w), int'(wr_short_err), int'(wr_of(w) < WR_MIN));
      check("R6", $sformatf("ap_delay code %0d", w), int'(ap_delay), wr_of(w) + TRP);
    end
    mrs(mk(0, 2, 0, 0, 1, 0));
  endtask

  task automatic t_test_mode();
    mrs(mk(0, 2, 0, 1, 1, 0));
    check("R2", "fault", int'(test_fault), 1);
    check("R2", "cmd_ok", int'(cmd_ok), 0);
    check("R2", "rd_ok", int'(rd_ok), 0);
    mrs(mk(0, 2, 0, 0, 1, 0));
    check("R2", "cleared", int'({test_fault, cmd_ok, rd_ok}), 3);
  endtask

  task automatic t_dll();
    mrs(mk(0, 2, 1, 0, 1, 0));
    check("R3", "pulse", int'(dll_rst_pulse), 1);
    check("R3", "bit8 reads 0", int'(mr_image[8]), 0);
    check("R4", "rd blocked", int'(rd_ok), 0);
    check("R4", "cmd allowed", int'(cmd_ok), 1);
    rd_req = 1'b1;
    cyc(1);
    rd_req = 1'b0;
    check("R3", "pulse one cycle", int'(dll_rst_pulse), 0);
    check("R11", "req_err on blocked read", int'(req_err), 1);
    cmd_req = 1'b1;
    cyc(1);
    cmd_req = 1'b0;
    check("R11", "no req_err for allowed cmd", int'(req_err), 0);
    cyc(TDLLK - 3);
    check("R4", "last blocked cycle", int'(rd_ok), 0);
    cyc(1);
    check("R4", "lock done", int'(rd_ok), 1);
  endtask

  task automatic t_dll_restart();
    mrs(mk(0, 2, 1, 0, 1, 0));
    cyc(100);
    mrs(mk(0, 2, 1, 0, 1, 0));
    cyc(TDLLK - 1);
    check("R10", "restarted window blocked", int'(rd_ok), 0);
    cyc(1);
    check("R10", "restarted window done", int'(rd_ok), 1);
  endtask

  task automatic t_pd(input bit fast);
    string tag;
    int n;
    tag = fast ? "R8" : "R7";
    n = fast ? TXP : TXPDLL;
    mrs(mk(fast, 2, 0, 0, 1, 0));
    pd_exit = 1'b1;
    cyc(1);
    pd_exit = 1'b0;
    check("R8", "stray exit ignored", int'(cmd_ok), 1);
    pd_enter = 1'b1;
    cyc(1);
    pd_enter = 1'b0;
    check(tag, "cmd blocked in pd", int'(cmd_ok), 0);
    check(tag, "rd blocked in pd", int'(rd_ok), 0);
    check(tag, "dll_frozen", int'(dll_frozen), int'(!fast));
    cyc(3);
    check(tag, "still in pd", int'(cmd_ok), 0);
    pd_exit = 1'b1;
    cyc(1);
    pd_exit = 1'b0;
    check(tag, "frozen released", int'(dll_frozen), 0);
    cyc(n - 1);
    check(tag, "last exit-wait cycle", int'(cmd_ok), 0);
    cyc(1);
    check(tag, "exit wait done", int'(cmd_ok), 1);
    check(tag, "reads back", int'(rd_ok), 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_cas();
    t_reserved();
    t_wr();
    t_test_mode();
    t_dll();
    t_dll_restart();
    t_pd(1'b0);
    t_pd(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule